// File: doc/BRIEF.md
# Double-Buffered Serial DAC Register Front End

This block is the digital side of a serial-input digital-to-analog converter. A host shifts a 16-bit code in MSB first on a serial clock while the device is selected. A write strobe then copies the shifted word into an input register. An independent update edge moves the input register into the DAC register, and that register's value is the parallel code sent to the converter. Because the two registers are separate, several converters can be loaded one at a time and then changed together by one common update edge.

A rising edge on a re-initialise pin forces both registers either to zero or to midscale, chosen by a select pin, whatever the other controls are doing. The bit leaving the top of the shift register is presented on a serial output, so that devices can be chained. All pins are brought into the system clock domain through a configurable synchronizer, and every action is taken on a system clock edge.

Top module: `dac_serial_front`

## Requirements
- R1: The shift register takes `ser_din` into bit 0 and moves every bit one place toward bit 15 on each rising edge of `ser_clk` while `sel_n` is low (MSB first). While `sel_n` is high, `ser_clk` edges leave it unchanged.
- R2: `ser_dout` always equals bit 15 of the shift register. This is the bit that the next serial clock pushes out.
- R3: While `sel_n` and `wr_n` are both low, the input register takes the shift register's value, and `dac_code` keeps its value.
- R4: A low level on `wr_n` while `sel_n` is high does not change the input register.
- R5: A rising edge on `upd` while `sel_n` and `wr_n` are both high copies the input register to `dac_code`. The input register keeps its value.
- R6: A rising edge on `upd` while `sel_n` or `wr_n` is low leaves `dac_code` unchanged. So does holding `upd` at a steady level.
- R7: A rising edge on `reinit` sets both registers to 16'h0000 when `reinit_mid` is low, and to 16'h8000 when it is high. This takes priority over every other control and does not change the shift register.
- R8: While `rst` is high, the shift register and both registers are cleared, so `dac_code` and `ser_dout` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial data in, MSB first |
| sel_n | input | 1 | Device select, active low |
| wr_n | input | 1 | Input-register write strobe, active low |
| upd | input | 1 | DAC update; acts on its rising edge |
| reinit | input | 1 | Re-initialise; acts on its rising edge |
| reinit_mid | input | 1 | Target of re-initialise: 0 gives zero code, 1 gives midscale |
| ser_dout | output | 1 | Serial data out for chaining (bit 15 of the shift register) |
| dac_code | output | 16 | DAC register value |

## Verification
The input register can only be observed through `dac_code`, one update edge later. A wrong write or a write that is missed therefore shows up only when the bench issues an update. For this reason every write scenario ends with an update followed by a compare. A corrupted shift register appears on `ser_dout` on the next serial clock. The bench finds it by shifting a known word through and reading it back bit by bit. A wrong decode of an update or re-initialise edge shows up on `dac_code` within the synchronizer latency plus one cycle.

// File: rtl/dac_if_pkg.sv
`timescale 1ns/1ps
package dac_if_pkg;

    localparam int unsigned DEF_CODE_W = 16;

    // Pin bundle carried through the synchronizer
    typedef struct packed {
        logic sclk;
        logic sdi;
        logic sel_n;
        logic wr_n;
        logic upd;
        logic clr;
        logic clr_mid;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, sdi: 1'b0, sel_n: 1'b1,
                                    wr_n: 1'b1, upd: 1'b0, clr: 1'b0,
                                    clr_mid: 1'b0};

    typedef enum logic [1:0] {
        MODE_HOLD   = 2'd0,
        MODE_WRITE  = 2'd1,
        MODE_UPDATE = 2'd2,
        MODE_CLEAR  = 2'd3
    } reg_mode_t;

    function automatic reg_mode_t pick_mode(logic clr_rise, logic upd_rise,
                                            logic sel_n, logic wr_n);
        if (clr_rise)
            return MODE_CLEAR;
        else if (!sel_n && !wr_n)
            return MODE_WRITE;
        else if (upd_rise && sel_n && wr_n)
            return MODE_UPDATE;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/pin_sync.sv
`timescale 1ns/1ps
module pin_sync
    import dac_if_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t d,
    output pins_t q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            pins_t chain [STAGES];
            for (genvar i = 0; i < STAGES; i++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst)
                        chain[i] <= PINS_IDLE;
                    else if (i == 0)
                        chain[i] <= d;
                    else
                        chain[i] <= chain[(i == 0) ? 0 : i - 1];
                end
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/edge_pick.sv
`timescale 1ns/1ps
module edge_pick (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic upd,
    input  logic clr,
    output logic sclk_rise,
    output logic upd_rise,
    output logic clr_rise
);
    logic sclk_d, upd_d, clr_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            upd_d  <= 1'b0;
            clr_d  <= 1'b0;
        end else begin
            sclk_d <= sclk;
            upd_d  <= upd;
            clr_d  <= clr;
        end
    end

    assign sclk_rise = sclk & ~sclk_d;
    assign upd_rise  = upd  & ~upd_d;
    assign clr_rise  = clr  & ~clr_d;
endmodule

// File: rtl/serial_shift.sv
`timescale 1ns/1ps
module serial_shift #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         dout
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else if (shift_en)
            sh_q <= {sh_q[W-2:0], din};
    end

    assign word = sh_q;
    assign dout = sh_q[W-1];

    // R1
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> sh_q == {$past(sh_q[W-2:0]), $past(din)});

    // R1
    shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sh_q));
endmodule

// File: rtl/dac_regs.sv
`timescale 1ns/1ps
module dac_regs
    import dac_if_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel_n,
    input  logic         wr_n,
    input  logic         upd_rise,
    input  logic         clr_rise,
    input  logic         clr_mid,
    input  logic [W-1:0] shift_word,
    output logic [W-1:0] dac_q
);
    localparam logic [W-1:0] MID_CODE  = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ZERO_CODE = '0;

    reg_mode_t    mode;
    logic [W-1:0] in_q;

    always_comb mode = pick_mode(clr_rise, upd_rise, sel_n, wr_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= ZERO_CODE;
            dac_q <= ZERO_CODE;
        end else begin
            unique case (mode)
                MODE_CLEAR: begin
                    in_q  <= clr_mid ? MID_CODE : ZERO_CODE;
                    dac_q <= clr_mid ? MID_CODE : ZERO_CODE;
                end
                MODE_WRITE:  in_q  <= shift_word;
                MODE_UPDATE: dac_q <= in_q;
                default: ;
            endcase
        end
    end

    // R3
    write_keeps_dac_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !wr_n && !clr_rise) |=> $stable(dac_q));

    // R4
    desel_write_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_n && !clr_rise) |=> $stable(in_q));

    // R5
    update_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_rise && sel_n && wr_n && !clr_rise) |=> dac_q == $past(in_q));

    // R6
    stray_update_chk: assert property (@(posedge clk) disable iff (rst)
        ((!upd_rise || !sel_n || !wr_n) && !clr_rise) |=> $stable(dac_q));

    // R7
    clear_target_chk: assert property (@(posedge clk) disable iff (rst)
        clr_rise |=> (dac_q == ($past(clr_mid) ? MID_CODE : ZERO_CODE))
                     && (in_q == dac_q));
endmodule

// File: rtl/dac_serial_front.sv
`timescale 1ns/1ps
module dac_serial_front
    import dac_if_pkg::*;
#(
    parameter int unsigned CODE_W      = DEF_CODE_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              upd,
    input  logic              reinit,
    input  logic              reinit_mid,
    output logic              ser_dout,
    output logic [CODE_W-1:0] dac_code
);
    pins_t              pins_raw, pins_s;
    logic               sclk_rise, upd_rise, clr_rise;
    logic [CODE_W-1:0]  shift_word;

    assign pins_raw = '{sclk: ser_clk, sdi: ser_din, sel_n: sel_n,
                        wr_n: wr_n, upd: upd, clr: reinit,
                        clr_mid: reinit_mid};

    pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    edge_pick u_edge (
        .clk       (clk),
        .rst       (rst),
        .sclk      (pins_s.sclk),
        .upd       (pins_s.upd),
        .clr       (pins_s.clr),
        .sclk_rise (sclk_rise),
        .upd_rise  (upd_rise),
        .clr_rise  (clr_rise)
    );

    serial_shift #(.W(CODE_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sclk_rise & ~pins_s.sel_n),
        .din      (pins_s.sdi),
        .word     (shift_word),
        .dout     (ser_dout)
    );

    dac_regs #(.W(CODE_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .sel_n      (pins_s.sel_n),
        .wr_n       (pins_s.wr_n),
        .upd_rise   (upd_rise),
        .clr_rise   (clr_rise),
        .clr_mid    (pins_s.clr_mid),
        .shift_word (shift_word),
        .dac_q      (dac_code)
    );

    // R2
    sdo_top_bit_chk: assert property (@(posedge clk) disable iff (rst)
        ser_dout == shift_word[CODE_W-1]);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dac_code == '0) && !ser_dout);
endmodule

// File: tb/tb_dac_serial_front.sv
`timescale 1ns/1ps
module tb_dac_serial_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0, ser_din = 1'b0, sel_n = 1'b1, wr_n = 1'b1;
    logic        upd = 1'b0, reinit = 1'b0, reinit_mid = 1'b0;
    logic        ser_dout;
    logic [15:0] dac_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dac_serial_front dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
        .sel_n(sel_n), .wr_n(wr_n), .upd(upd), .reinit(reinit),
        .reinit_mid(reinit_mid), .ser_dout(ser_dout), .dac_code(dac_code)
    );

    // op: 0 shift+write, 1 update, 2 reinit, 3 shift only
    // entry = {op[1:0], mid, data[15:0], expected dac[15:0]}
    localparam int NV = 13;
    localparam logic [34:0] VEC [NV] = '{
        {2'd0, 1'b0, 16'hA5C3, 16'h0000},   // R3 write, dac holds
        {2'd1, 1'b0, 16'h0000, 16'hA5C3},   // R5
        {2'd0, 1'b0, 16'h1234, 16'hA5C3},   // R3
        {2'd2, 1'b1, 16'h0000, 16'h8000},   // R7 midscale
        {2'd1, 1'b0, 16'h0000, 16'h8000},   // R7 input reg also mid
        {2'd0, 1'b0, 16'hFFFF, 16'h8000},
        {2'd1, 1'b0, 16'h0000, 16'hFFFF},   // R5
        {2'd2, 1'b0, 16'h0000, 16'h0000},   // R7 zero
        {2'd1, 1'b0, 16'h0000, 16'h0000},   // R7 input reg also zero
        {2'd3, 1'b0, 16'h7E81, 16'h0000},   // R1 shift without write
        {2'd1, 1'b0, 16'h0000, 16'h0000},   // R3 nothing written
        {2'd0, 1'b0, 16'h0001, 16'h0000},
        {2'd1, 1'b0, 16'h0000, 16'h0001}    // R1 LSB lands
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_din = b;  tick(4);
        ser_clk = 1'b1; tick(4);
        ser_clk = 1'b0;
    endtask

    task automatic shift_word(input logic [15:0] w);
        sel_n = 1'b0; tick(2);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
        tick(6);
    endtask

    task automatic write_pulse();
        wr_n = 1'b0; tick(4);
        wr_n = 1'b1; tick(6);
    endtask

    task automatic update_pulse();
        upd = 1'b1; tick(6);
        upd = 1'b0; tick(6);
    endtask

    task automatic reinit_pulse(input logic mid);
        reinit_mid = mid; tick(2);
        reinit = 1'b1; tick(6);
        reinit = 1'b0; tick(6);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(5);
        // R8 reset state
        check("R8 dac", dac_code, 16'h0000);
        check("R8 sdo", {15'd0, ser_dout}, 16'h0000);
        rst = 1'b0;
        tick(4);

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  op;
            logic        mid;
            logic [15:0] data, expv;
            {op, mid, data, expv} = VEC[v];
            case (op)
                2'd0: begin shift_word(data); write_pulse(); sel_n = 1'b1; tick(4); end
                2'd1: update_pulse();
                2'd2: reinit_pulse(mid);
                default: begin shift_word(data); sel_n = 1'b1; tick(4); end
            endcase
            check($sformatf("R3/R5/R7 vector %0d", v), dac_code, expv);
        end

        // R2: shift register holds 0001; read it back MSB first
        sel_n = 1'b0; tick(4);
        for (int i = 15; i >= 0; i--) begin
            check("R2 sdo bit", {15'd0, ser_dout}, {15'd0, (i == 0)});
            send_bit(1'b0);
        end
        tick(6);
        check("R2 sdo after drain", {15'd0, ser_dout}, 16'h0000);
        sel_n = 1'b1; tick(4);

        // R4: write strobe while deselected is ignored
        shift_word(16'hBEEF);
        sel_n = 1'b1; tick(4);
        write_pulse();
        update_pulse();
        check("R4 desel write", dac_code, 16'h0001);

        // R1: serial clocks while deselected do not shift
        for (int i = 0; i < 16; i++) send_bit(1'b1);
        tick(6);
        check("R1 desel sdo", {15'd0, ser_dout}, 16'h0001);
        sel_n = 1'b0; tick(4);
        write_pulse();
        sel_n = 1'b1; tick(4);
        update_pulse();
        check("R1 desel shift", dac_code, 16'hBEEF);

        // R6: update edges blocked by select or write strobe
        shift_word(16'hCAFE);
        write_pulse();
        update_pulse();                     // sel_n still low
        check("R6 upd while selected", dac_code, 16'hBEEF);
        sel_n = 1'b1; tick(4);
        wr_n = 1'b0; tick(4);
        update_pulse();                     // wr_n low
        wr_n = 1'b1; tick(6);
        check("R6 upd during write", dac_code, 16'hBEEF);
        upd = 1'b1; tick(2);
        upd = 1'b1; tick(4);
        check("R5 upd edge", dac_code, 16'hCAFE);
        shift_word(16'h0F0F);
        write_pulse();
        sel_n = 1'b1; tick(10);
        check("R6 upd level held", dac_code, 16'hCAFE);
        upd = 1'b0; tick(6);
        check("R6 upd falling", dac_code, 16'hCAFE);

        // R7: reinit overrides a simultaneous update edge
        reinit_mid = 1'b1; tick(2);
        upd = 1'b1; reinit = 1'b1; tick(6);
        upd = 1'b0; reinit = 1'b0; tick(6);
        check("R7 override", dac_code, 16'h8000);
        // R7: shift register untouched (holds 0F0F, top bit 0)
        check("R7 shift kept", {15'd0, ser_dout}, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule